// File: doc/BRIEF.md
# Two-Channel Offset Calibration and Correction

This block removes a static DC offset from two independent streams of 10-bit offset-binary samples, one sample per channel on every clock. A rising edge on the calibration request launches a fixed 34-clock sequence. During that sequence, each channel sums 32 of its own samples while the inputs are held at zero signal. It then rounds the mean and stores it as a signed distance from midscale (512).

After the sequence ends, each channel subtracts its stored distance from every new sample and clamps the result to 0..1023. Both corrected results are registered, so each one appears one clock after its sample. A busy flag covers the whole sequence. While the flag is high, the outputs are still corrected, using the estimate held before the sequence began.

Top module: `ofs_cal_top`

## Requirements
- R1: A sequence starts only when the calibration request is sampled high one clock after it was sampled low. A request held high never starts a second sequence.
- R2: `busy_o` rises at the clock edge that samples the request edge and stays high for exactly 34 consecutive clock cycles.
- R3: The samples presented during busy cycles 2 through 33 (32 samples) are summed. The new estimate is (sum + 16) >> 5 minus 512, so an exact half rounds up. Samples in busy cycles 1 and 34 are not used.
- R4: Each channel computes and applies its own estimate from its own samples only.
- R5: Each output is registered. It equals clamp(sample − estimate, 0, 1023) for the sample presented one clock earlier.
- R6: A new estimate applies to samples presented after the last busy cycle. Samples presented while busy are corrected with the previous estimate.
- R7: A request edge that arrives while busy is ignored. It neither restarts nor lengthens the sequence.
- R8: After reset, both estimates are zero, `busy_o` is low and both outputs are 0.
- R9: A difference below 0 gives output 0. A difference above 1023 gives output 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_req_i | input | 1 | Calibration request, acted on at its rising edge |
| smp_a_i | input | 10 | Channel A sample, offset binary |
| smp_b_i | input | 10 | Channel B sample, offset binary |
| out_a_o | output | 10 | Channel A corrected sample |
| out_b_o | output | 10 | Channel B corrected sample |
| busy_o | output | 1 | High during the calibration sequence |

## Verification
The assertions assume that the calibration request is a synchronous level that is low while reset is applied. Under that assumption, a request edge seen by the checker is also a request edge for the block. The stimulus keeps the request low through reset and changes it only between clock edges. It holds the request high across whole sequences and pulses it low and high again in the middle of one sequence. This covers the held-level case and the ignored-edge case without violating the assumption. Sample values use distinct filler codes in the setup and load cycles, so any error in the accumulation window changes the resulting estimates.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;

  // Clamp a signed difference into the unsigned code range [0, 2^dw-1].
  function automatic logic [15:0] clamp_code(input logic signed [17:0] d, input int dw);
    logic signed [17:0] top;
    top = 18'sd1 <<< dw;
    top = top - 18'sd1;
    if (d < 18'sd0) begin
      return 16'd0;
    end else if (d > top) begin
      return top[15:0];
    end else begin
      return d[15:0];
    end
  endfunction

endpackage

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq #(
  parameter int NAVG_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o,
  output logic clr_o,
  output logic acc_en_o,
  output logic load_o
);
  localparam int NAVG = 1 << NAVG_LOG2;
  localparam int LAST = NAVG + 1;
  localparam int CW   = $clog2(NAVG + 2);

  logic          req_q, req_n;
  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rise;

  always_comb begin
    rise   = req_i & ~req_q;
    req_n  = req_i;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (busy_q) begin
      if (cnt_q == CW'(LAST)) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (rise) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_q  <= req_n;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy_o   = busy_q;
  assign clr_o    = busy_q && (cnt_q == '0);
  assign acc_en_o = busy_q && (cnt_q != '0) && (cnt_q != CW'(LAST));
  assign load_o   = busy_q && (cnt_q == CW'(LAST));

endmodule

// File: rtl/ofs_cal_chan.sv
module ofs_cal_chan
  import ofs_cal_pkg::*;
#(
  parameter int DW        = 10,
  parameter int NAVG_LOG2 = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          acc_en_i,
  input  logic          load_i,
  input  logic [DW-1:0] smp_i,
  output logic [DW-1:0] out_o
);
  localparam int AW  = DW + NAVG_LOG2;
  localparam int EW  = DW + 1;
  localparam int XW  = DW + 2;
  localparam int MID = 1 << (DW - 1);

  logic [AW-1:0]        acc_q, acc_n;
  logic signed [EW-1:0] est_q, est_n;
  logic [DW-1:0]        out_q, out_n;
  logic [AW-1:0]        rnd;
  logic [DW-1:0]        avg;
  logic signed [XW-1:0] diff;
  logic [15:0]          clamped;

  always_comb begin
    acc_n = acc_q;
    if (clr_i) begin
      acc_n = '0;
    end else if (acc_en_i) begin
      acc_n = acc_q + AW'(smp_i);
    end
    rnd   = acc_q + AW'(1 << (NAVG_LOG2 - 1));
    avg   = rnd[AW-1:NAVG_LOG2];
    est_n = est_q;
    if (load_i) begin
      est_n = $signed({1'b0, avg}) - $signed(EW'(MID));
    end
    diff    = $signed({2'b00, smp_i}) - $signed({est_q[EW-1], est_q});
    clamped = clamp_code(18'(diff), DW);
    out_n   = clamped[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      est_q <= '0;
      out_q <= '0;
    end else begin
      acc_q <= acc_n;
      est_q <= est_n;
      out_q <= out_n;
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/ofs_cal_top.sv
module ofs_cal_top #(
  parameter int DW        = 10,
  parameter int NAVG_LOG2 = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cal_req_i,
  input  logic [DW-1:0] smp_a_i,
  input  logic [DW-1:0] smp_b_i,
  output logic [DW-1:0] out_a_o,
  output logic [DW-1:0] out_b_o,
  output logic          busy_o
);
  localparam int NCH = 2;

  logic          clr, acc_en, load;
  logic [DW-1:0] smp [NCH];
  logic [DW-1:0] res [NCH];

  assign smp[0]  = smp_a_i;
  assign smp[1]  = smp_b_i;
  assign out_a_o = res[0];
  assign out_b_o = res[1];

  ofs_cal_seq #(.NAVG_LOG2(NAVG_LOG2)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (cal_req_i),
    .busy_o  (busy_o),
    .clr_o   (clr),
    .acc_en_o(acc_en),
    .load_o  (load)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ofs_cal_chan #(.DW(DW), .NAVG_LOG2(NAVG_LOG2)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .acc_en_i(acc_en),
      .load_i  (load),
      .smp_i   (smp[c]),
      .out_o   (res[c])
    );
  end

endmodule

// File: rtl/ofs_cal_chk.sv
module ofs_cal_chk #(
  parameter int NAVG_LOG2 = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cal_req_i,
  input logic busy_o
);
  localparam int WIN = (1 << NAVG_LOG2) + 2;

  logic        prev_q;
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= cal_req_i;
      run_q  <= busy_o ? run_q + 16'd1 : 16'd0;
    end
  end

  // R1: an idle request edge starts a sequence
  a_r1_edge_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cal_req_i && !prev_q) |=> busy_o);

  // R1: a held level does not start one
  a_r1_level_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cal_req_i && prev_q) |=> !busy_o);

  // R2, R7: the sequence is exactly WIN cycles long
  a_r2_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 16'(WIN)));

  // R7: busy never exceeds the window even with edges arriving inside it
  a_r7_no_extend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < 16'(WIN)));

endmodule

bind ofs_cal_top ofs_cal_chk #(.NAVG_LOG2(NAVG_LOG2)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cal_req_i(cal_req_i),
  .busy_o   (busy_o)
);

// File: tb/ofs_cal_top_test.sv
`timescale 1ns/1ps
module ofs_cal_top_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cal_req_i = 1'b0;
  logic [9:0] smp_a_i = '0;
  logic [9:0] smp_b_i = '0;
  logic [9:0] out_a_o, out_b_o;
  logic       busy_o;

  always #2.5 clk_i = ~clk_i;

  ofs_cal_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cal_req_i(cal_req_i),
    .smp_a_i(smp_a_i), .smp_b_i(smp_b_i),
    .out_a_o(out_a_o), .out_b_o(out_b_o), .busy_o(busy_o)
  );

  typedef struct {
    int    a;
    int    b;
    bit    busy;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // Model state, derived from the requirements
  int est_a = 0, est_b = 0, acc_a = 0, acc_b = 0, cnt = 0;
  bit m_busy = 0, m_req = 0;

  function automatic int clampv(int d);
    if (d < 0) return 0;
    if (d > 1023) return 1023;
    return d;
  endfunction

  task automatic drive(int a, int b, bit req, string tag);
    exp_t e;
    @(negedge clk_i);
    smp_a_i   = 10'(a);
    smp_b_i   = 10'(b);
    cal_req_i = req;
    e.a   = clampv(a - est_a);
    e.b   = clampv(b - est_b);
    e.tag = tag;
    if (m_busy) begin
      if (cnt >= 1 && cnt <= 32) begin
        acc_a += a;
        acc_b += b;
      end
      if (cnt == 33) begin
        est_a  = ((acc_a + 16) >> 5) - 512;
        est_b  = ((acc_b + 16) >> 5) - 512;
        m_busy = 0;
      end
      cnt++;
    end else if (req && !m_req) begin
      m_busy = 1;
      cnt    = 0;
      acc_a  = 0;
      acc_b  = 0;
    end
    m_req  = req;
    e.busy = m_busy;
    q.push_back(e);
  endtask

  // Monitor: compares each result one clock after its sample
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int'(out_a_o) != e.a || int'(out_b_o) != e.b || busy_o != e.busy) begin
          errors++;
          $display("FAIL %s: got a=%0d b=%0d busy=%0b, expected a=%0d b=%0d busy=%0b",
                   e.tag, out_a_o, out_b_o, busy_o, e.a, e.b, e.busy);
        end
      end
    end
  end

  // 35 drives: edge, setup, 32 accumulation, load. The request stays high (R1 held level).
  task automatic calib(int a0, int a1, int b0, int b1, bit glitch, string tag);
    for (int i = 0; i < 35; i++) begin
      bit r;
      r = 1'b1;
      if (glitch && i == 10) r = 1'b0;
      if (i >= 2 && i <= 33) begin
        drive((i % 2) ? a1 : a0, (i % 2) ? b1 : b0, r, tag);
      end else begin
        drive(900, 77, r, tag);
      end
    end
  endtask

  initial begin
    #12;
    checks++;
    if (out_a_o != 0 || out_b_o != 0 || busy_o != 0) begin
      errors++;
      $display("FAIL R8: reset got a=%0d b=%0d busy=%0b, expected 0 0 0", out_a_o, out_b_o, busy_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: zero estimate, samples pass unchanged
    drive(0, 1023, 0, "R8 passthrough");
    drive(512, 300, 0, "R8 passthrough");
    drive(1023, 0, 0, "R8 passthrough");

    // R3, R4: A mean 520 (+8), B mean 500.5 rounds to 501 (-11). Request held (R1, R2).
    calib(520, 520, 500, 501, 0, "R2 R3 first window");
    drive(0, 0, 1, "R1 held request no retrigger");
    drive(1023, 1023, 1, "R9 clamp after R4 calibration");
    drive(600, 600, 1, "R5 R4 corrected");
    drive(8, 489, 0, "R5 R4 corrected");
    drive(300, 700, 0, "R5 corrected");

    // R7: glitch mid-sequence is ignored; R6: old estimate used while busy.
    // A mean 0.5 rounds to 1 (-511), B mean 1023 (+511).
    calib(0, 1, 1023, 1023, 1, "R6 R7 second window");
    drive(1023, 0, 0, "R9 clamp high and low");
    drive(200, 600, 0, "R5 after recalibration");
    drive(0, 1023, 0, "R5 after recalibration");
    drive(512, 511, 1, "R1 new edge starts");
    drive(512, 511, 1, "R6 previous estimate while busy");
    repeat (3) drive(512, 512, 0, "R6 previous estimate while busy");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule